// File: doc/BRIEF.md
# Queued Scatter-Gather Memory Copy Engine

This block copies words from one memory region to another on behalf of a processor, so the processor spends no cycles on the copy. Software pushes transfer descriptors, each giving a source address, a destination address, a word count and an end-of-chain flag, into a four-entry queue. The engine pops the descriptors in order. For each word it reads the source over a request/grant bus and then writes the destination. A run of descriptors ending in one with the end flag set forms a chain, so scattered pieces of memory can be gathered into one contiguous area, or the reverse.

The way the engine shares the bus is chosen per descriptor. In burst mode it keeps its request up for the whole descriptor. In cycle-stealing mode it lets go of the bus for a cycle after every word it writes. In background mode it requests only while the processor reports that it is not using the bus. The engine pulses an interrupt when a chain finishes.

The descriptor port is valid/ready. A descriptor is taken on a clock edge where both signals are high, and `desc_ready` is low while the queue is full. A producer may hold `desc_valid` high for as long as it needs to. The bus port is not back-pressured on the data side. A bus cycle completes on an edge where both `bus_req` and `bus_gnt` are high, and read data must be valid in that same cycle.

Top module: `dma_sg_engine`

## Requirements
- R1: A descriptor is accepted on a rising edge where `desc_valid` and `desc_ready` are both high. Up to four accepted descriptors wait in the queue.
- R2: For each word k of a descriptor, the engine reads address src+k and then writes that value to address dst+k, for k running upward from 0. A read handshake is always followed by a write request in the next cycle. Addresses outside the destination range are never written.
- R3: When `mode_sel` = 0 (burst) at the moment a descriptor starts, `bus_req` stays high without a break from the first read request until the write handshake of the descriptor's last word.
- R4: When `mode_sel` = 1 (cycle stealing), `bus_req` is low in the cycle after every write handshake.
- R5: When `mode_sel` = 2 or 3 (background), `bus_req` is never high while `cpu_busy` is high. The transfer pauses while the processor is busy, resumes afterwards and loses no data.
- R6: Descriptors run in the order they were pushed. A chain whose pieces point at adjacent destinations produces one contiguous copy.
- R7: When the queue holds four descriptors, `desc_ready` is low and it stays low until the engine takes an entry. A descriptor offered while the queue is full is dropped and has no effect on memory.
- R8: `irq_done` is high for exactly one cycle after the last write of a descriptor whose end flag is set. A descriptor whose end flag is clear raises no pulse.
- R9: A descriptor with a word count of 0 finishes without raising `bus_req`. If its end flag is set, it still raises `irq_done`.
- R10: In burst and cycle-stealing modes, a request that is not granted stays high, and `bus_addr`, `bus_we` and `bus_wdata` hold their values until the grant arrives.
- R11: After reset, `desc_ready` is 1, and `bus_req` and `irq_done` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Queue can take a descriptor |
| desc_src | input | ADDR_W | Source start address (word address) |
| desc_dst | input | ADDR_W | Destination start address (word address) |
| desc_len | input | LEN_W | Number of words to copy |
| desc_last | input | 1 | End-of-chain flag |
| mode_sel | input | 2 | 0 burst, 1 cycle stealing, 2 or 3 background; sampled when a descriptor starts |
| cpu_busy | input | 1 | Processor is using the bus this cycle |
| bus_req | output | 1 | Bus cycle requested |
| bus_gnt | input | 1 | Bus cycle granted; the cycle completes when this and bus_req are both high |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Word address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid in the grant cycle |
| irq_done | output | 1 | One-cycle pulse when a chain completes |

## Verification
The hardest state to reach from the ports is a full queue, because the engine takes a descriptor out of the queue as soon as it is idle. The bench gets there by holding the grant low, so that the first descriptor stays stuck at its first read. It then pushes four more descriptors and offers a fifth, which must be refused. Once the grant is released, it confirms that the refused descriptor's destination is still untouched. A background-mode transfer is also held with `cpu_busy` high for a long stretch, to show that the request stays off and no data is lost. The bus-sharing rules are checked on every cycle by a monitor while randomised grant and busy patterns run.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    MODE_BURST    = 2'd0,
    MODE_STEAL    = 2'd1,
    MODE_IDLE     = 2'd2,
    MODE_IDLE_ALT = 2'd3
  } bus_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_RD,
    ST_WR,
    ST_GAP
  } eng_state_e;

endpackage

// File: rtl/dma_desc_queue.sv
module dma_desc_queue #(
  parameter int W     = 25,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_pop,
  output logic [W-1:0] out_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);
  localparam logic [PW-1:0] P_ONE    = PW'(1);
  localparam logic [CW-1:0] C_ONE    = CW'(1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign in_ready  = (count != FULL_CNT);
  assign out_valid = (count != '0);
  assign do_push   = in_valid && in_ready;
  assign do_pop    = out_pop && out_valid;
  assign out_data  = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + P_ONE;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + P_ONE;
      case ({do_push, do_pop})
        2'b10:   count <= count + C_ONE;
        2'b01:   count <= count - C_ONE;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/dma_bus_gate.sv
module dma_bus_gate
  import dma_pkg::*;
(
  input  bus_mode_e mode,
  input  logic      cpu_busy,
  output logic      allow
);
  always_comb begin
    unique case (mode)
      MODE_BURST, MODE_STEAL: allow = 1'b1;
      default:                allow = !cpu_busy;
    endcase
  end
endmodule

// File: rtl/dma_copy_engine.sv
module dma_copy_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_valid,
  output logic              q_pop,
  input  logic [ADDR_W-1:0] q_src,
  input  logic [ADDR_W-1:0] q_dst,
  input  logic [LEN_W-1:0]  q_len,
  input  logic              q_last,
  input  logic [1:0]        mode_in,
  input  logic              allow,
  output bus_mode_e         mode_q,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
  localparam logic [LEN_W-1:0]  L_ONE = LEN_W'(1);

  eng_state_e        state;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              last_q;
  logic [DATA_W-1:0] hold_q;
  logic              want, fire;

  assign q_pop     = (state == ST_IDLE) && q_valid;
  assign want      = (state == ST_RD) || (state == ST_WR);
  assign bus_req   = want && allow;
  assign fire      = bus_req && bus_gnt;
  assign bus_we    = (state == ST_WR);
  assign bus_addr  = (state == ST_WR) ? dst_q : src_q;
  assign bus_wdata = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
      hold_q <= '0;
      mode_q <= MODE_BURST;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (q_valid) begin
            src_q  <= q_src;
            dst_q  <= q_dst;
            cnt_q  <= q_len;
            last_q <= q_last;
            mode_q <= bus_mode_e'(mode_in);
            state  <= ST_CHK;
          end
        end
        ST_CHK: begin
          if (cnt_q == '0) begin
            irq   <= last_q;
            state <= ST_IDLE;
          end else begin
            state <= ST_RD;
          end
        end
        ST_RD: begin
          if (fire) begin
            hold_q <= bus_rdata;
            state  <= ST_WR;
          end
        end
        ST_WR: begin
          if (fire) begin
            src_q <= src_q + A_ONE;
            dst_q <= dst_q + A_ONE;
            cnt_q <= cnt_q - L_ONE;
            if (cnt_q == L_ONE) begin
              irq   <= last_q;
              state <= ST_IDLE;
            end else if (mode_q == MODE_STEAL) begin
              state <= ST_GAP;
            end else begin
              state <= ST_RD;
            end
          end
        end
        ST_GAP:  state <= ST_RD;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_sg_engine.sv
module dma_sg_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [ADDR_W-1:0] desc_src,
  input  logic [ADDR_W-1:0] desc_dst,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic              desc_last,
  input  logic [1:0]        mode_sel,
  input  logic              cpu_busy,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              irq_done
);
  localparam int DW_Q = 1 + LEN_W + 2 * ADDR_W;

  logic [DW_Q-1:0]   q_in, q_out;
  logic              q_valid, q_pop, allow;
  bus_mode_e         mode_q;
  logic [ADDR_W-1:0] q_src, q_dst;
  logic [LEN_W-1:0]  q_len;
  logic              q_last;

  assign q_in = {desc_last, desc_len, desc_dst, desc_src};
  assign {q_last, q_len, q_dst, q_src} = q_out;

  dma_desc_queue #(.W(DW_Q), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .in_valid(desc_valid), .in_ready(desc_ready), .in_data(q_in),
    .out_valid(q_valid), .out_pop(q_pop), .out_data(q_out)
  );

  dma_bus_gate u_gate (
    .mode(mode_q), .cpu_busy(cpu_busy), .allow(allow)
  );

  dma_copy_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .q_valid(q_valid), .q_pop(q_pop),
    .q_src(q_src), .q_dst(q_dst), .q_len(q_len), .q_last(q_last),
    .mode_in(mode_sel), .allow(allow), .mode_q(mode_q),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq_done)
  );
endmodule

// File: rtl/dma_sg_engine_chk.sv
module dma_sg_engine_chk
  import dma_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              cpu_busy,
  input logic              irq_done,
  input logic              desc_ready,
  input logic              q_pop,
  input bus_mode_e         mode_q
);
  // R2: a read handshake is followed by a write request
  p_read_then_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && !bus_we) |=> bus_we);

  // R3: burst keeps the request up between a word's read and its write
  p_burst_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_BURST && bus_req && bus_gnt && !bus_we) |=> bus_req);

  // R4: cycle stealing releases the bus after each write
  p_steal_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STEAL && bus_req && bus_gnt && bus_we) |=> !bus_req);

  // R5: background mode never requests while the processor is busy
  p_bg_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && cpu_busy) |-> (mode_q == MODE_BURST || mode_q == MODE_STEAL));

  // R7: a full queue stays full until the engine pops
  p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!desc_ready && !q_pop) |=> !desc_ready);

  // R8: completion interrupt is a single-cycle pulse
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);

  // R10: an ungranted request holds steady outside background mode
  p_req_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && (mode_q == MODE_BURST || mode_q == MODE_STEAL))
    |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));
endmodule

bind dma_sg_engine dma_sg_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .cpu_busy(cpu_busy), .irq_done(irq_done), .desc_ready(desc_ready),
  .q_pop(q_pop), .mode_q(mode_q)
);

// File: tb/dma_sg_engine_tb.sv
module dma_sg_engine_tb;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int LW = 8;
  localparam int NVEC = 7;
  // {mode[2], gnt_pat[2], busy_pat[2], len[8], src[8], dst[8]}
  localparam logic [29:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 2'd0, 8'd5, 8'h10, 8'h80},
    {2'd0, 2'd1, 2'd1, 8'd7, 8'h20, 8'h90},
    {2'd1, 2'd0, 2'd0, 8'd6, 8'h30, 8'hA0},
    {2'd1, 2'd1, 2'd1, 8'd4, 8'h38, 8'hB0},
    {2'd2, 2'd0, 2'd1, 8'd8, 8'h40, 8'hC0},
    {2'd2, 2'd1, 2'd1, 8'd3, 8'h50, 8'hD0},
    {2'd3, 2'd0, 2'd1, 8'd2, 8'h58, 8'hE0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic desc_valid = 1'b0;
  logic desc_ready;
  logic [AW-1:0] desc_src = '0, desc_dst = '0;
  logic [LW-1:0] desc_len = '0;
  logic desc_last = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic cpu_busy;
  logic bus_req, bus_gnt, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic irq_done;

  logic [DW-1:0] mem [256];
  logic fill_req = 1'b0;
  logic clr_mon = 1'b0;
  logic [1:0] gnt_mode = 2'd0, busy_mode = 2'd0;
  logic [15:0] lfsr = 16'hACE1;
  int mon_len = 0;
  int irq_cnt, req_cnt, steal_viol, bg_viol, burst_viol, wr_seen;
  logic prev_steal_wr, prev_req;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  dma_sg_engine #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .QDEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_src(desc_src), .desc_dst(desc_dst), .desc_len(desc_len),
    .desc_last(desc_last), .mode_sel(mode_sel), .cpu_busy(cpu_busy),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_done(irq_done)
  );

  function automatic logic [DW-1:0] pat(input int a);
    logic [7:0] b = a[7:0];
    return {8'hC3, b, ~b, b ^ 8'h5A};
  endfunction

  assign bus_rdata = mem[bus_addr];

  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
    end else if (bus_req && bus_gnt && bus_we) begin
      mem[bus_addr] <= bus_wdata;
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    bus_gnt  <= (gnt_mode == 2'd0) ? 1'b1 : (gnt_mode == 2'd1) ? lfsr[0] : 1'b0;
    cpu_busy <= (busy_mode == 2'd0) ? 1'b0 : (busy_mode == 2'd1) ? (lfsr[3] | lfsr[7]) : 1'b1;
  end

  always @(posedge clk) begin
    if (clr_mon || !rst_n) begin
      irq_cnt <= 0; req_cnt <= 0; steal_viol <= 0; bg_viol <= 0;
      burst_viol <= 0; wr_seen <= 0; prev_steal_wr <= 1'b0; prev_req <= 1'b0;
    end else begin
      if (irq_done) irq_cnt <= irq_cnt + 1;
      if (bus_req) req_cnt <= req_cnt + 1;
      if (bus_req && bus_gnt && bus_we) wr_seen <= wr_seen + 1;
      if (prev_steal_wr && bus_req) steal_viol <= steal_viol + 1;
      if (mode_sel[1] && bus_req && cpu_busy) bg_viol <= bg_viol + 1;
      if (mode_sel == 2'd0 && prev_req && !bus_req && wr_seen < mon_len)
        burst_viol <= burst_viol + 1;
      prev_steal_wr <= (mode_sel == 2'd1) && bus_req && bus_gnt && bus_we;
      prev_req <= bus_req;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fill();
    @(negedge clk) fill_req = 1'b1;
    @(negedge clk) fill_req = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk) clr_mon = 1'b1;
    @(negedge clk) clr_mon = 1'b0;
  endtask

  task automatic push(input int s, input int d, input int n, input logic l);
    @(negedge clk);
    desc_src = AW'(s); desc_dst = AW'(d); desc_len = LW'(n); desc_last = l;
    desc_valid = 1'b1;
    while (!desc_ready) @(negedge clk);
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  task automatic offer_once(input int s, input int d, input int n, output logic took);
    @(negedge clk);
    desc_src = AW'(s); desc_dst = AW'(d); desc_len = LW'(n); desc_last = 1'b1;
    desc_valid = 1'b1;
    took = desc_ready;
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  task automatic wait_irq(input int n);
    for (int c = 0; c < 3000 && irq_cnt < n; c++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic took;
    int bad;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 ready", 32'(desc_ready), 32'd1);
    check("R11 req", 32'(bus_req), 32'd0);
    check("R11 irq", 32'(irq_done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table of single-descriptor transfers across modes and bus patterns
    for (int v = 0; v < NVEC; v++) begin
      logic [29:0] e = VEC[v];
      int n = int'(e[23:16]);
      int s = int'(e[15:8]);
      int d = int'(e[7:0]);
      do_fill();
      mode_sel = e[29:28]; gnt_mode = e[27:26]; busy_mode = e[25:24];
      mon_len = n;
      do_clr();
      push(s, d, n, 1'b1);
      wait_irq(1);
      check("R8 one irq per chain", 32'(irq_cnt), 32'd1);
      bad = 0;
      for (int k = 0; k < n; k++) if (mem[d + k] !== pat(s + k)) bad++;
      check("R2 destination copy", 32'(bad), 32'd0);
      check("R2 beyond range untouched", mem[d + n], pat(d + n));
      if (e[29:28] == 2'd0) check("R3 burst hold", 32'(burst_viol), 32'd0);
      else if (e[29:28] == 2'd1) check("R4 steal gap", 32'(steal_viol), 32'd0);
      else check("R5 background quiet", 32'(bg_viol), 32'd0);
    end

    // R6 / R8: three-piece gather chain, end flag only on the final piece
    do_fill();
    mode_sel = 2'd1; gnt_mode = 2'd1; busy_mode = 2'd0; mon_len = 0;
    do_clr();
    push(8'h10, 8'h60, 3, 1'b0);
    push(8'h30, 8'h63, 2, 1'b0);
    push(8'h48, 8'h65, 4, 1'b1);
    wait_irq(1);
    repeat (20) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 3; k++) if (mem[8'h60 + k] !== pat(8'h10 + k)) bad++;
    for (int k = 0; k < 2; k++) if (mem[8'h63 + k] !== pat(8'h30 + k)) bad++;
    for (int k = 0; k < 4; k++) if (mem[8'h65 + k] !== pat(8'h48 + k)) bad++;
    check("R6 gather order", 32'(bad), 32'd0);
    check("R8 no irq for non-last", 32'(irq_cnt), 32'd1);
    check("R4 steal gap in chain", 32'(steal_viol), 32'd0);

    // R9: zero-length descriptor
    mode_sel = 2'd0; gnt_mode = 2'd0;
    do_clr();
    push(8'h00, 8'h70, 0, 1'b1);
    repeat (10) @(negedge clk);
    check("R9 zero-length irq", 32'(irq_cnt), 32'd1);
    check("R9 zero-length no request", 32'(req_cnt), 32'd0);

    // R1 / R7 / R10: fill the queue behind a stalled transfer
    do_fill();
    gnt_mode = 2'd2; mode_sel = 2'd0; mon_len = 0;
    do_clr();
    push(8'h05, 8'hEE, 1, 1'b1);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4; i++) push(8'h20 + i, 8'hF0 + i, 1, 1'b1);
    check("R7 ready low when full", 32'(desc_ready), 32'd0);
    check("R10 request held", 32'(bus_req), 32'd1);
    check("R10 address held", 32'(bus_addr), 32'h05);
    offer_once(8'h08, 8'hF8, 1, took);
    check("R7 push refused when full", 32'(took), 32'd0);
    gnt_mode = 2'd0;
    wait_irq(5);
    repeat (20) @(negedge clk);
    check("R1 five descriptors complete", 32'(irq_cnt), 32'd5);
    bad = 0;
    for (int i = 0; i < 4; i++) if (mem[8'hF0 + i] !== pat(8'h20 + i)) bad++;
    check("R1 queued copies", 32'(bad), 32'd0);
    check("R7 refused push no effect", mem[8'hF8], pat(8'hF8));
    check("R7 ready after drain", 32'(desc_ready), 32'd1);

    // R5: background stall while processor busy, then resume
    do_fill();
    mode_sel = 2'd2; busy_mode = 2'd2; gnt_mode = 2'd0;
    do_clr();
    push(8'h44, 8'h74, 2, 1'b1);
    repeat (30) @(negedge clk);
    check("R5 no request while busy", 32'(req_cnt), 32'd0);
    check("R5 destination untouched while busy", mem[8'h74], pat(8'h74));
    busy_mode = 2'd0;
    wait_irq(1);
    check("R5 resumed word 0", mem[8'h74], pat(8'h44));
    check("R5 resumed word 1", mem[8'h75], pat(8'h45));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule